// File: doc/BRIEF.md
# Serial Target Front End for a 16-Bit Port Expander

This block is the two-wire serial target side of a 16-bit port expander. It watches SCL and SDA, both sampled by the system clock at a rate well above the bus bit rate. It finds START and STOP conditions and takes in the address byte. It answers only when the address matches a 7-bit value with a fixed upper part and a lower part taken from three strap inputs, so several expanders can share one bus. It pulls SDA low through an open-drain enable and never drives the line high.

In a write transaction, the byte after the address is a command byte. Its three low bits set an internal pointer that cannot be read back. The pointer selects one of eight byte-wide registers. Every later data byte goes to or comes from the selected register over a small internal register bus. The port and register logic sits on the far side of that bus. After each data byte the pointer flips its lowest bit, so a burst of bytes alternates between the two halves of a register pair. A master can write the pointer, send a repeated START and read back without a STOP in between.

Top module: `gpx_i2c_target`

## Requirements
- R1: While reset is held and in the first cycle after it, `sda_oe_o`, `reg_wr_o` and `reg_rd_o` are all 0.
- R2: An address byte whose upper seven bits equal binary 0100 followed by `strap_i[2]`, `strap_i[1]`, `strap_i[0]` (MSB first) is acknowledged: SDA is pulled low during the ninth clock. The eighth bit picks the direction: 1 means the master reads and 0 means it writes. `sda_oe_o` changes only while SCL is low.
- R3: An address that does not match is not acknowledged. Later bytes up to the next START cause no acknowledge and no register-bus strobe.
- R4: In a write, the first byte after the address is acknowledged and produces no strobe. Its bits [2:0] load the pointer and its upper five bits are ignored. The pointer keeps its value across STOP and START.
- R5: Each later write byte is acknowledged. For a writable target it gives a one-cycle `reg_wr_o` with `reg_idx_o` equal to the pointer and `reg_wdata_o` equal to the byte.
- R6: A write byte aimed at index 0 or 1 (the input registers) is still acknowledged but produces no `reg_wr_o`.
- R7: After every data byte, read or written, bit 0 of the pointer is inverted.
- R8: At the start of every read byte, a one-cycle `reg_rd_o` is issued with `reg_idx_o` equal to the pointer. `reg_rdata_i` is taken on the following cycle and shifted out MSB first on SDA.
- R9: A repeated START after a write enters a new address phase, and a read then starts at the pointer left by the write.
- R10: When the master does not acknowledge a read byte, the read ends and no further `reg_rd_o` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Strap bits forming the low three address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_idx_o | output | 3 | Register index for the current strobe |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data for the register bus |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read data from the register bus |

## Verification
Addresses are tried in three forms: one that matches, one with wrong strap bits, and one with a wrong fixed part. This separates a full seven-bit compare from a partial one, and a second strap setting shows the compare follows the straps. Write bursts go to a writable pair and to the input pair. Comparing acknowledges with the strobes shows that protected writes are acknowledged yet dropped. Command bytes with set upper bits show that only three bits load the pointer. Read bursts of two and three bytes, started both by a repeated START and by a fresh START, use data with mixed bit values. The strobe index sequence exposes errors in pointer toggling, pointer retention and bit order, and the count of read strobes after a master NACK shows that the read really ends.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int DW    = 8;
    localparam int PTR_W = 3;
    localparam int CNT_W = $clog2(DW + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } xfer_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

    // Index 0 and 1 are the input pair and cannot be written
    function automatic logic idx_writable(input logic [PTR_W-1:0] idx);
        return idx[PTR_W-1:1] != '0;
    endfunction

    function automatic logic addr_hit(input logic [6:0] rx_addr,
                                      input logic [3:0] fixed_part,
                                      input logic [2:0] strap);
        return rx_addr == {fixed_part, strap};
    endfunction

endpackage

// File: rtl/gpx_line_sync.sv
module gpx_line_sync
    import gpx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_i,
    output line_ev_t ev_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    always_comb begin
        ev_o.level = chain[STAGES-1];
        ev_o.rise  = chain[STAGES-1] & ~prev;
        ev_o.fall  = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/gpx_bus_cond.sv
module gpx_bus_cond (
    input  logic scl_level,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_o,
    output logic stop_o
);
    // SDA moving while SCL stays high marks a bus condition
    always_comb begin
        start_o = scl_level & sda_fall;
        stop_o  = scl_level & sda_rise;
    end
endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target
    import gpx_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] FIXED_ADDR  = 4'b0100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [2:0]       strap_i,
    output logic             sda_oe_o,
    output logic [PTR_W-1:0] reg_idx_o,
    output logic             reg_wr_o,
    output logic [DW-1:0]    reg_wdata_o,
    output logic             reg_rd_o,
    input  logic [DW-1:0]    reg_rdata_i
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

    line_ev_t scl_ev, sda_ev;
    logic     start_c, stop_c;

    gpx_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .line_i(scl_i), .ev_o(scl_ev)
    );
    gpx_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .line_i(sda_i), .ev_o(sda_ev)
    );
    gpx_bus_cond u_cond (
        .scl_level(scl_ev.level), .sda_rise(sda_ev.rise),
        .sda_fall(sda_ev.fall), .start_o(start_c), .stop_o(stop_c)
    );

    xfer_state_e      state;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]    shreg;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] idx_q;
    logic [DW-1:0]    wdata_q;
    logic             wr_q, rd_q, load_pend, rnw, master_ack;
    logic             rx_phase, rx_bit, rx_done;

    always_comb begin
        rx_phase = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WDATA);
        rx_bit   = rx_phase && scl_ev.rise && (bit_cnt != FULL);
        rx_done  = rx_phase && scl_ev.fall && (bit_cnt == FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            ptr        <= '0;
            idx_q      <= '0;
            wdata_q    <= '0;
            wr_q       <= 1'b0;
            rd_q       <= 1'b0;
            load_pend  <= 1'b0;
            rnw        <= 1'b0;
            master_ack <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
            if (load_pend) begin
                shreg     <= reg_rdata_i;
                load_pend <= 1'b0;
            end
            if (stop_c) begin
                state     <= ST_IDLE;
                load_pend <= 1'b0;
            end else if (start_c) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                load_pend <= 1'b0;
            end else if (rx_bit) begin
                shreg   <= {shreg[DW-2:0], sda_ev.level};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (rx_done) begin
                bit_cnt <= '0;
                unique case (state)
                    ST_ADDR: begin
                        if (addr_hit(shreg[DW-1:1], FIXED_ADDR, strap_i)) begin
                            rnw   <= shreg[0];
                            state <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_CMD: begin
                        ptr   <= shreg[PTR_W-1:0];
                        state <= ST_CMD_ACK;
                    end
                    default: begin
                        wr_q    <= idx_writable(ptr);
                        idx_q   <= ptr;
                        wdata_q <= shreg;
                        ptr[0]  <= ~ptr[0];
                        state   <= ST_WDATA_ACK;
                    end
                endcase
            end else begin
                unique case (state)
                    ST_ADDR_ACK: if (scl_ev.fall) begin
                        bit_cnt <= '0;
                        if (rnw) begin
                            state     <= ST_RDATA;
                            rd_q      <= 1'b1;
                            idx_q     <= ptr;
                            load_pend <= 1'b1;
                        end else begin
                            state <= ST_CMD;
                        end
                    end
                    ST_CMD_ACK, ST_WDATA_ACK: if (scl_ev.fall) begin
                        bit_cnt <= '0;
                        state   <= ST_WDATA;
                    end
                    ST_RDATA: if (scl_ev.fall) begin
                        shreg   <= {shreg[DW-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == LAST) begin
                            ptr[0] <= ~ptr[0];
                            state  <= ST_RDATA_ACK;
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (scl_ev.rise) master_ack <= ~sda_ev.level;
                        if (scl_ev.fall) begin
                            bit_cnt <= '0;
                            if (master_ack) begin
                                state     <= ST_RDATA;
                                rd_q      <= 1'b1;
                                idx_q     <= ptr;
                                load_pend <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_RDATA:                              sda_oe_o = ~load_pend & ~shreg[DW-1];
            default:                               sda_oe_o = 1'b0;
        endcase
    end

    assign reg_idx_o   = idx_q;
    assign reg_wr_o    = wr_q;
    assign reg_wdata_o = wdata_q;
    assign reg_rd_o    = rd_q;

endmodule

// File: rtl/gpx_i2c_target_chk.sv
module gpx_i2c_target_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic [2:0] reg_idx_o,
    input logic       reg_wr_o,
    input logic       reg_rd_o
);
    assert_wr_single_R5: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |=> !reg_wr_o);

    assert_rd_single_R8: assert property (@(posedge clk) disable iff (rst)
        reg_rd_o |=> !reg_rd_o);

    assert_no_input_write_R6: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |-> (reg_idx_o[2:1] != 2'b00));

    assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr_o && reg_rd_o));

    assert_oe_moves_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind gpx_i2c_target gpx_i2c_target_chk chk_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .reg_idx_o(reg_idx_o), .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o)
);

// File: tb/gpx_i2c_target_tb_top.sv
module gpx_i2c_target_tb_top;
    localparam int Q = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_bus;
    logic       sda_oe;
    logic [2:0] reg_idx;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] bank [8];
    logic [2:0] rd_log [32];
    int         wr_cnt, rd_cnt;
    int         n_chk = 0, n_err = 0;

    always #5 clk = ~clk;

    assign sda_bus   = m_sda & ~sda_oe;
    assign reg_rdata = bank[reg_idx];

    gpx_i2c_target dut_i (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(strap),
        .sda_oe_o(sda_oe), .reg_idx_o(reg_idx), .reg_wr_o(reg_wr),
        .reg_wdata_o(reg_wdata), .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata)
    );

    // Register bank model behind the internal bus
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) bank[i] <= 8'h00;
            bank[0] <= 8'h5A;
            bank[1] <= 8'hC3;
            wr_cnt  <= 0;
            rd_cnt  <= 0;
        end else begin
            if (reg_wr) begin
                bank[reg_idx] <= reg_wdata;
                wr_cnt        <= wr_cnt + 1;
            end
            if (reg_rd) begin
                if (rd_cnt < 32) rd_log[rd_cnt] <= reg_idx;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; wait_q();
        m_scl = 1'b1; wait_q(); wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        b = sda_bus; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic write_byte(input logic [7:0] d, output logic acked);
        logic nb;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(nb);
        acked = ~nb;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            bit_in(b);
            d[i] = b;
        end
        bit_out(~give_ack);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check("R1", sda_oe, 1'b0, "oe during reset");
        rst = 1'b0;
        @(negedge clk);
        check("R1", sda_oe, 1'b0, "oe after reset");
        check("R1", reg_wr, 1'b0, "wr after reset");
        check("R1", reg_rd, 1'b0, "rd after reset");
    endtask

    task automatic t_wrong_addr();
        logic ak;
        int w0 = wr_cnt, r0 = rd_cnt;
        bus_start();
        write_byte({7'b0100_011, 1'b0}, ak);
        check("R3", ak, 1'b0, "strap mismatch ack");
        write_byte(8'h02, ak);
        check("R3", ak, 1'b0, "byte after mismatch ack");
        write_byte(8'h77, ak);
        bus_stop();
        bus_start();
        write_byte({7'b1100_101, 1'b0}, ak);
        check("R3", ak, 1'b0, "fixed part mismatch ack");
        bus_stop();
        check("R3", wr_cnt - w0, 0, "writes after mismatch");
        check("R3", rd_cnt - r0, 0, "reads after mismatch");
    endtask

    task automatic t_write_pair();
        logic ak;
        int w0 = wr_cnt;
        bus_start();
        write_byte({7'b0100_101, 1'b0}, ak);
        check("R2", ak, 1'b1, "own address ack");
        write_byte(8'hF2, ak);
        check("R4", ak, 1'b1, "command ack");
        write_byte(8'hA5, ak);
        check("R5", ak, 1'b1, "data ack");
        write_byte(8'h3C, ak);
        check("R7", ak, 1'b1, "second data ack");
        bus_stop();
        check("R4", wr_cnt - w0, 2, "write strobes (command gives none)");
        check("R5", bank[2], 8'hA5, "output 0 value");
        check("R7", bank[3], 8'h3C, "toggled to output 1");
    endtask

    task automatic t_input_then_rstart_read();
        logic ak;
        logic [7:0] d;
        int w0 = wr_cnt, r0 = rd_cnt;
        bus_start();
        write_byte({7'b0100_101, 1'b0}, ak);
        write_byte(8'h08, ak);
        write_byte(8'h11, ak);
        check("R6", ak, 1'b1, "input write ack");
        write_byte(8'h22, ak);
        check("R6", ak, 1'b1, "input write ack 2");
        check("R6", wr_cnt - w0, 0, "no strobe to input pair");
        bus_start();
        write_byte({7'b0100_101, 1'b1}, ak);
        check("R9", ak, 1'b1, "read address ack after repeated start");
        read_byte(1'b1, d);
        check("R9", d, 8'h5A, "first read from pointer 0");
        read_byte(1'b0, d);
        check("R7", d, 8'hC3, "second read toggled to 1");
        bus_stop();
        check("R10", rd_cnt - r0, 2, "read strobes after nack");
        check("R8", rd_log[r0], 3'd0, "first read index");
        check("R8", rd_log[r0 + 1], 3'd1, "second read index");
    endtask

    task automatic t_config_burst();
        logic ak;
        logic [7:0] d;
        int r0;
        bus_start();
        write_byte({7'b0100_101, 1'b0}, ak);
        write_byte(8'h07, ak);
        write_byte(8'hF0, ak);
        write_byte(8'h0F, ak);
        bus_stop();
        check("R7", bank[7], 8'hF0, "config 1 value");
        check("R7", bank[6], 8'h0F, "config 0 value");
        r0 = rd_cnt;
        bus_start();
        write_byte({7'b0100_101, 1'b1}, ak);
        read_byte(1'b1, d);
        check("R4", d, 8'hF0, "pointer kept across stop");
        read_byte(1'b1, d);
        check("R8", d, 8'h0F, "second burst byte");
        read_byte(1'b0, d);
        check("R8", d, 8'hF0, "third burst byte");
        repeat (4) bit_out(1'b1);
        check("R10", rd_cnt - r0, 3, "no read after nack");
        bus_stop();
        check("R8", rd_log[r0 + 1], 3'd6, "burst index 2");
        check("R8", rd_log[r0 + 2], 3'd7, "burst index 3");
    endtask

    task automatic t_strap_change();
        logic ak;
        strap = 3'b010;
        repeat (4) @(negedge clk);
        bus_start();
        write_byte({7'b0100_101, 1'b0}, ak);
        check("R2", ak, 1'b0, "old strap address after change");
        bus_stop();
        bus_start();
        write_byte({7'b0100_010, 1'b0}, ak);
        check("R2", ak, 1'b1, "new strap address");
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_wrong_addr();
        t_write_pair();
        t_input_then_rstart_read();
        t_config_burst();
        t_strap_change();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule